// File: doc/BRIEF.md
# Eight-Line Priority Interrupt Controller

This block gathers eight interrupt request lines into one interrupt output for a processor. A rising edge on a request line is latched as pending. A per-line mask can hold a pending request back without losing it. A priority resolver chooses one winner among the unmasked pending lines. It forwards that winner only when the winner outranks every line already in service, so interrupt service nests properly.

When the processor answers the interrupt output with an acknowledge pulse, the controller does three things. It clears the winner's pending bit, marks the winner as in service, and registers an 8-bit vector. The vector is the programmed base with the winner's index in its low bits. Software then uses an end-of-interrupt command to retire the highest-ranked in-service line.

Priority runs in one of two orders. The fixed order ranks line 0 first. The rotating order moves the line just retired to the bottom of the ranking, which shares service evenly among busy lines. A small write port sets the mask, the priority order and the vector base, and issues the end-of-interrupt command.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `int_o` is low, `vec_o` is 0x00, every line is masked, fixed order is selected, nothing is pending or in service, and the lowest-priority pointer sits at line 7.
- R2: A 0-to-1 transition on `irq_i[k]`, seen at a clock edge, latches line k as pending. A line held high for many cycles latches once and does not request again until it has gone low and risen again.
- R3: A pending line whose mask bit is 1 never raises `int_o`. It stays latched, and it raises `int_o` once its mask bit is cleared.
- R4: In fixed order, among unmasked pending lines the lowest index wins, so line 0 ranks highest and line 7 lowest.
- R5: A pending winner drives `int_o` high only if it outranks every in-service line. A request that ranks at or below the highest in-service line waits until that line is retired.
- R6: A clock edge with `ack_i` high while `int_o` is high does three things. It registers `vec_o` = {base[7:3], winner index[2:0]}, clears the winner's pending bit and sets its in-service bit.
- R7: A clock edge with `ack_i` high while `int_o` is low changes neither `vec_o` nor any pending or in-service bit.
- R8: An end-of-interrupt command clears only the in-service bit that ranks highest under the current order. With nothing in service it has no effect.
- R9: In rotating order, the line retired by an end-of-interrupt becomes the lowest priority, and the line after it (index + 1 modulo 8) becomes the highest. End-of-interrupt commands in fixed order leave the pointer unchanged.
- R10: A write sets a field chosen by `wr_sel`. Code 0 loads the mask from `wr_data[7:0]`, where 1 means masked. Code 1 loads the order from `wr_data[0]`, where 1 means rotating. Code 2 loads the base from `wr_data[7:3]` and ignores bits [2:0]. Code 3 issues end-of-interrupt and ignores the data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| irq_i | input | 8 | Interrupt request lines, rising-edge sensitive |
| wr_en | input | 1 | Write strobe for the configuration and command port |
| wr_sel | input | 2 | Write target: 0 mask, 1 order, 2 vector base, 3 end-of-interrupt |
| wr_data | input | 8 | Write data |
| ack_i | input | 1 | Acknowledge from the processor, one cycle per interrupt taken |
| int_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Vector of the line most recently acknowledged |

## Verification
The assertions check four things on every cycle. The interrupt output only rises when an unmasked line is pending. An accepted acknowledge leaves a vector that carries the programmed base and names a line now in service. An acknowledge that arrives with no interrupt outstanding leaves the vector unchanged. An end-of-interrupt removes exactly one in-service line.

The following can only be shown by the bench's scenarios:
- which line actually wins under the fixed and rotating orders;
- that a lower-ranked request waits behind an in-service line;
- that a held-high input requests only once;
- how the rotation pointer moves across a full round of busy lines.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

  // Write-port targets selected by wr_sel
  typedef enum logic [1:0] {
    SEL_MASK = 2'd0,
    SEL_MODE = 2'd1,
    SEL_BASE = 2'd2,
    SEL_EOI  = 2'd3
  } wr_sel_e;

endpackage

// File: rtl/irq_edge_latch.sv
// Rising-edge detection and pending-request register.
module irq_edge_latch #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irq_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);

  logic [N-1:0] prev_q, prev_d;
  logic [N-1:0] pend_q, pend_d;

  always_comb begin
    prev_d = irq_i;
    // a fresh edge wins over a clear in the same cycle
    pend_d = (pend_q & ~clr_i) | (irq_i & ~prev_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= prev_d;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/irq_prio_pick.sv
// Finds the first set bit starting from index top_i and wrapping around.
module irq_prio_pick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req_i,
  input  logic [IW-1:0] top_i,
  output logic          hit_o,
  output logic [IW-1:0] idx_o
);

  logic [N-1:0]  rot;
  logic [IW-1:0] off;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      rot[i] = req_i[IW'(i) + top_i];
    end
    hit_o = 1'b0;
    off   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (rot[i]) begin
        hit_o = 1'b1;
        off   = IW'(i);
      end
    end
    idx_o = top_i + off;
  end

endmodule

// File: rtl/irq_cfg_regs.sv
// Write-port decode: mask, priority order, vector base, end-of-interrupt strobe.
module irq_cfg_regs
  import prio_irq_pkg::*;
#(
  parameter int N     = 8,
  parameter int VEC_W = 8,
  parameter int IW    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [VEC_W-1:0]  wr_data,
  output logic [N-1:0]      mask_o,
  output logic              rot_o,
  output logic [VEC_W-IW-1:0] base_o,
  output logic              eoi_o
);

  localparam int BW = VEC_W - IW;

  wr_sel_e       sel;
  logic [N-1:0]  mask_q, mask_d;
  logic          rot_q, rot_d;
  logic [BW-1:0] base_q, base_d;
  logic          mask_en, rot_en, base_en;

  always_comb begin
    sel     = wr_sel_e'(wr_sel);
    mask_en = wr_en && (sel == SEL_MASK);
    rot_en  = wr_en && (sel == SEL_MODE);
    base_en = wr_en && (sel == SEL_BASE);
    eoi_o   = wr_en && (sel == SEL_EOI);
    mask_d  = wr_data[N-1:0];
    rot_d   = wr_data[0];
    base_d  = wr_data[VEC_W-1:IW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      rot_q  <= 1'b0;
      base_q <= '0;
    end else begin
      if (mask_en) mask_q <= mask_d;
      if (rot_en)  rot_q  <= rot_d;
      if (base_en) base_q <= base_d;
    end
  end

  assign mask_o = mask_q;
  assign rot_o  = rot_q;
  assign base_o = base_q;

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int N_LINES = 8,
  parameter int VEC_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_i,
  input  logic               wr_en,
  input  logic [1:0]         wr_sel,
  input  logic [VEC_W-1:0]   wr_data,
  input  logic               ack_i,
  output logic               int_o,
  output logic [VEC_W-1:0]   vec_o
);

  localparam int IW = $clog2(N_LINES);
  localparam int BW = VEC_W - IW;

  // reset synchronizer: asserts at once, releases on the clock
  logic [1:0] rst_sync_q;
  logic       rst_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync = rst_sync_q[1];

  logic [N_LINES-1:0] pend, mask, win_oh, eoi_oh;
  logic               rot_mode, eoi_stb;
  logic [BW-1:0]      vbase;
  logic [N_LINES-1:0] isr_q, isr_d;
  logic [IW-1:0]      lowp_q, lowp_d, top_pri;
  logic [VEC_W-1:0]   vec_q, vec_d;
  logic               req_hit, isr_hit, take, isr_en, lowp_en;
  logic [IW-1:0]      req_idx, isr_idx, rank_req, rank_isr;

  irq_cfg_regs #(.N(N_LINES), .VEC_W(VEC_W), .IW(IW)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_sync),
    .wr_en  (wr_en),
    .wr_sel (wr_sel),
    .wr_data(wr_data),
    .mask_o (mask),
    .rot_o  (rot_mode),
    .base_o (vbase),
    .eoi_o  (eoi_stb)
  );

  irq_edge_latch #(.N(N_LINES)) u_edge (
    .clk   (clk),
    .rst_n (rst_sync),
    .irq_i (irq_i),
    .clr_i (win_oh),
    .pend_o(pend)
  );

  assign top_pri = rot_mode ? lowp_q + IW'(1) : '0;

  irq_prio_pick #(.N(N_LINES), .IW(IW)) u_pick_req (
    .req_i(pend & ~mask),
    .top_i(top_pri),
    .hit_o(req_hit),
    .idx_o(req_idx)
  );

  irq_prio_pick #(.N(N_LINES), .IW(IW)) u_pick_isr (
    .req_i(isr_q),
    .top_i(top_pri),
    .hit_o(isr_hit),
    .idx_o(isr_idx)
  );

  always_comb begin
    rank_req = req_idx - top_pri;
    rank_isr = isr_idx - top_pri;
    int_o    = req_hit && (!isr_hit || (rank_req < rank_isr));
    take     = ack_i && int_o;
    win_oh   = take ? ({{(N_LINES-1){1'b0}}, 1'b1} << req_idx) : '0;
    eoi_oh   = (eoi_stb && isr_hit) ? ({{(N_LINES-1){1'b0}}, 1'b1} << isr_idx) : '0;
    isr_en   = take || (eoi_stb && isr_hit);
    isr_d    = (isr_q | win_oh) & ~eoi_oh;
    lowp_en  = eoi_stb && isr_hit && rot_mode;
    lowp_d   = isr_idx;
    vec_d    = {vbase, req_idx};
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      isr_q  <= '0;
      lowp_q <= IW'(N_LINES - 1);
      vec_q  <= '0;
    end else begin
      if (isr_en)  isr_q  <= isr_d;
      if (lowp_en) lowp_q <= lowp_d;
      if (take)    vec_q  <= vec_d;
    end
  end

  assign vec_o = vec_q;

endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int N_LINES = 8,
  parameter int VEC_W   = 8
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             ack_i,
  input logic                             int_o,
  input logic [VEC_W-1:0]                 vec_o,
  input logic [N_LINES-1:0]               isr,
  input logic [N_LINES-1:0]               pend,
  input logic [N_LINES-1:0]               mask,
  input logic [VEC_W-$clog2(N_LINES)-1:0] base,
  input logic                             eoi
);

  localparam int IW = $clog2(N_LINES);

  // R1: interrupt output is quiet right after reset release
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !int_o);

  // R3: interrupt output needs an unmasked pending line
  a_r3_int_needs_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    int_o |-> ((pend & ~mask) != '0));

  // R6: the accepted vector names a line that is now in service
  a_r6_vec_in_service: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && int_o) |=> isr[vec_o[IW-1:0]]);

  // R6: the accepted vector carries the programmed base
  a_r6_vec_base: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && int_o) |=> (vec_o[VEC_W-1:IW] == $past(base)));

  // R7: an acknowledge with no interrupt outstanding leaves the vector alone
  a_r7_idle_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !int_o) |=> $stable(vec_o));

  // R8: an end-of-interrupt removes exactly one in-service line
  a_r8_eoi_one: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && (isr != '0) && !(ack_i && int_o)) |=>
      ($countones(isr) == $countones($past(isr)) - 1));

endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.N_LINES(N_LINES), .VEC_W(VEC_W)) u_chk (
  .clk  (clk),
  .rst_n(rst_sync),
  .ack_i(ack_i),
  .int_o(int_o),
  .vec_o(vec_o),
  .isr  (isr_q),
  .pend (pend),
  .mask (mask),
  .base (vbase),
  .eoi  (eoi_stb)
);

// File: tb/prio_irq_ctrl_test.sv
`timescale 1ns/100ps
module prio_irq_ctrl_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] irq_i;
  logic       wr_en;
  logic [1:0] wr_sel;
  logic [7:0] wr_data;
  logic       ack_i;
  logic       int_o;
  logic [7:0] vec_o;

  int  n_run  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #2.5 clk = ~clk;

  prio_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .ack_i(ack_i), .int_o(int_o), .vec_o(vec_o)
  );

  // {request pattern, expected vector} with base 0xA8, fixed order
  localparam logic [15:0] TBL [6] = '{
    16'h01A8, 16'h80AF, 16'h90AC, 16'h0CAA, 16'hFFA8, 16'h60AD
  };

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    wr_sel = sel; wr_data = d; wr_en = 1'b1;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic eoi();
    wr(2'd3, 8'h00);
  endtask

  task automatic pulse(input logic [7:0] p);
    irq_i = p;
    cyc();
    irq_i = 8'h00;
  endtask

  task automatic do_ack();
    ack_i = 1'b1;
    cyc();
    ack_i = 1'b0;
  endtask

  task automatic drain();
    for (int k = 0; k < 8; k++) begin
      if (int_o) begin
        do_ack();
        eoi();
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; irq_i = 8'h00; wr_en = 1'b0; wr_sel = 2'd0;
    wr_data = 8'h00; ack_i = 1'b0;
    repeat (3) cyc();
    rst_n = 1'b1;
    repeat (3) cyc();

    // R1 reset state
    chk(int_o == 1'b0, "R1 int after reset", int_o, 0);
    chk(vec_o == 8'h00, "R1 vec after reset", vec_o, 0);

    // R3 masked at reset: latched but silent, then released by unmask
    pulse(8'h08);
    chk(int_o == 1'b0, "R3 masked line silent", int_o, 0);
    wr(2'd0, 8'h00);
    chk(int_o == 1'b1, "R3 unmask releases latched line", int_o, 1);
    do_ack();
    chk(vec_o == 8'h03, "R6 vector base 0 line 3", vec_o, 8'h03);
    eoi();
    chk(int_o == 1'b0, "R6 no re-request after ack", int_o, 0);

    // R10 base write ignores low bits; R4 table of fixed-order winners
    wr(2'd2, 8'hAD);
    for (int t = 0; t < 6; t++) begin
      pulse(TBL[t][15:8]);
      chk(int_o == 1'b1, "R2 edge raises int", int_o, 1);
      do_ack();
      chk(vec_o == TBL[t][7:0], "R4 fixed winner / R10 base", vec_o, TBL[t][7:0]);
      eoi();
      drain();
      chk(int_o == 1'b0, "R6 all requests consumed", int_o, 0);
    end

    // R5 nesting
    pulse(8'h10);
    do_ack();
    pulse(8'h40);
    chk(int_o == 1'b0, "R5 lower line blocked by in-service", int_o, 0);
    pulse(8'h04);
    chk(int_o == 1'b1, "R5 higher line preempts", int_o, 1);
    do_ack();
    chk(vec_o == 8'hAA, "R5 nested vector", vec_o, 8'hAA);
    eoi();
    chk(int_o == 1'b0, "R8 eoi retires line 2 only", int_o, 0);
    eoi();
    chk(int_o == 1'b1, "R8 eoi retires line 4, line 6 free", int_o, 1);
    do_ack();
    chk(vec_o == 8'hAE, "R5 waiting line served", vec_o, 8'hAE);
    eoi();

    // R7 idle acknowledge
    do_ack();
    chk(vec_o == 8'hAE, "R7 idle ack keeps vector", vec_o, 8'hAE);
    chk(int_o == 1'b0, "R7 idle ack no request", int_o, 0);

    // R3 individual mask
    wr(2'd0, 8'h01);
    pulse(8'h03);
    do_ack();
    chk(vec_o == 8'hA9, "R3 masked line 0 skipped", vec_o, 8'hA9);
    eoi();
    chk(int_o == 1'b0, "R3 masked line held back", int_o, 0);
    wr(2'd0, 8'h00);
    chk(int_o == 1'b1, "R3 unmasked line raises", int_o, 1);
    do_ack();
    chk(vec_o == 8'hA8, "R3 unmasked vector", vec_o, 8'hA8);
    eoi();

    // R9 rotating order
    wr(2'd1, 8'h01);
    pulse(8'h09);
    do_ack();
    chk(vec_o == 8'hA8, "R9 rot start line 0", vec_o, 8'hA8);
    eoi();
    do_ack();
    chk(vec_o == 8'hAB, "R9 rot next line 3", vec_o, 8'hAB);
    eoi();
    pulse(8'h05);
    do_ack();
    chk(vec_o == 8'hA8, "R9 line 0 outranks 2 after ptr=3", vec_o, 8'hA8);
    eoi();
    do_ack();
    chk(vec_o == 8'hAA, "R9 line 2 served", vec_o, 8'hAA);
    eoi();
    pulse(8'hFF);
    for (int k = 0; k < 8; k++) begin
      do_ack();
      chk(vec_o == (8'hA8 | 8'((3 + k) % 8)), "R9 full rotation round",
          vec_o, 8'hA8 | 8'((3 + k) % 8));
      eoi();
    end
    chk(int_o == 1'b0, "R9 round complete", int_o, 0);

    // R2 held-high input requests once
    irq_i = 8'h20;
    cyc();
    do_ack();
    chk(vec_o == 8'hAD, "R2 held line served", vec_o, 8'hAD);
    eoi();
    repeat (3) cyc();
    chk(int_o == 1'b0, "R2 held line no second request", int_o, 0);
    irq_i = 8'h00;
    cyc();

    // R1 reset mid-run restores quiet, masked state
    pulse(8'h02);
    rst_n = 1'b0;
    #1;
    chk(int_o == 1'b0, "R1 int in reset", int_o, 0);
    chk(vec_o == 8'h00, "R1 vec in reset", vec_o, 0);
    cyc();
    rst_n = 1'b1;
    repeat (3) cyc();
    pulse(8'h01);
    chk(int_o == 1'b0, "R1 lines masked after reset", int_o, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule